// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is the combinational logic core of a programmable sum-of-products device. A programmable AND plane builds product terms from the true and inverted forms of the dedicated inputs and the feedback signals. A fixed OR plane then combines a group of those terms into one sum for each output. The size of the group changes from output to output: the outer outputs get the fewest terms and the middle outputs get the most. Each output also has its own enable term. Two further terms are shared by every output. One serves as an asynchronous clear and the other as a synchronous set for the registers that follow the block.

The whole configuration arrives as one flat fuse vector, with one bit per crosspoint. The surrounding logic holds this vector, along with the macrocell registers, the output polarity logic and the pins. The block has no clock and no state: every output is a pure function of the inputs, the feedbacks and the fuses.

Top module: `pla_core`

## Requirements
- R1: The array has 44 columns. Column 2*i carries signal i in true form and column 2*i+1 carries it inverted. Signals 0..11 are din_i[0..11] and signals 12..21 are fb_i[0..9].
- R2: Within a row, a fuse bit of 1 means the column is connected (intact) and 0 means it is disconnected (blown). A product term is the AND of all connected columns.
- R3: A row with every fuse intact evaluates to 0 for any input values, because some signal is then connected in both forms.
- R4: A row with every fuse blown evaluates to 1.
- R5: Outputs 0..9 sum 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 product terms respectively. sum_o[k] is the OR of the terms in its own group only.
- R6: Row r takes fuse bits r*44 to r*44+43, with bit r*44+c holding column c. The rows are ordered by output, starting with output 0. Each output has one enable row followed by its sum rows. After output 9 come the clear row (row 130) and then the set row (row 131), for 132 rows in total.
- R7: oe_o[k] equals the product term of the enable row of output k.
- R8: arst_o equals the clear-row term and spre_o equals the set-row term. Neither depends on any sum or enable row.
- R9: The outputs follow a change on din_i, fb_i or fuse_i with no clock edge in between.
- R10: A term in the row just after an output's group (the next output's enable row) has no effect on that output's sum. The last row of a group does affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din_i | input | 12 | Dedicated input signals |
| fb_i | input | 10 | Feedback signals, one per output |
| fuse_i | input | 5808 | Flat fuse vector, 132 rows of 44 bits, 1 = connected |
| sum_o | output | 10 | Sum-of-products result per output |
| oe_o | output | 10 | Enable term per output |
| arst_o | output | 1 | Shared asynchronous clear term |
| spre_o | output | 1 | Shared synchronous set term |

## Verification
The bench builds the block with its default parameters: 12 inputs, 10 outputs, a minimum group of 8 terms and a step of 2. This gives the full 132-row layout, so both the shortest groups (8 terms) and the longest (16 terms) are reachable. It also exposes every edge between a group and the enable row that follows it. With these values the bench can program the first term of a short group, the last term of a long group, and rows adjacent to group edges, and then check at the outputs that only the intended output responds.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Number of product terms summed by output k: grows toward the middle.
  function automatic int terms_of(input int k, input int n_out,
                                  input int tmin, input int tstep);
    int d;
    d = (k < (n_out - 1 - k)) ? k : (n_out - 1 - k);
    return tmin + tstep * d;
  endfunction

  // First row (the enable row) belonging to output k.
  function automatic int group_base(input int k, input int n_out,
                                    input int tmin, input int tstep);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) begin
      acc += 1 + terms_of(j, n_out, tmin, tstep);
    end
    return acc;
  endfunction

endpackage

// File: rtl/pla_literals.sv
module pla_literals #(
  parameter int N_IN  = 12,
  parameter int N_OUT = 10,
  localparam int N_SIG = N_IN + N_OUT,
  localparam int N_COL = 2 * N_SIG
) (
  input  logic [N_IN-1:0]  din_i,
  input  logic [N_OUT-1:0] fb_i,
  output logic [N_COL-1:0] col_o
);

  logic [N_SIG-1:0] sig;
  assign sig = {fb_i, din_i};

  for (genvar i = 0; i < N_SIG; i++) begin : g_col
    assign col_o[2*i]   = sig[i];
    assign col_o[2*i+1] = ~sig[i];
  end

endmodule

// File: rtl/pla_product_term.sv
module pla_product_term #(
  parameter int N_COL = 44
) (
  input  logic [N_COL-1:0] col_i,
  input  logic [N_COL-1:0] fuse_i,
  output logic             term_o
);

  // A blown fuse (0) forces its column to a neutral 1.
  assign term_o = &(col_i | ~fuse_i);

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_COL  = 44,
  parameter int N_ROWS = 132,
  localparam int N_FUSE = N_ROWS * N_COL
) (
  input  logic [N_COL-1:0]  col_i,
  input  logic [N_FUSE-1:0] fuse_i,
  output logic [N_ROWS-1:0] term_o
);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    pla_product_term #(.N_COL(N_COL)) u_term (
      .col_i  (col_i),
      .fuse_i (fuse_i[r*N_COL +: N_COL]),
      .term_o (term_o[r])
    );
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_ROWS   = group_base(N_OUT, N_OUT, MIN_TERMS, TERM_STEP) + 2
) (
  input  logic [N_ROWS-1:0] term_i,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  oe_o,
  output logic              arst_o,
  output logic              spre_o
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int BASE = group_base(k, N_OUT, MIN_TERMS, TERM_STEP);
    localparam int CNT  = terms_of(k, N_OUT, MIN_TERMS, TERM_STEP);
    assign oe_o[k]  = term_i[BASE];
    assign sum_o[k] = |term_i[BASE+1 +: CNT];
  end

  assign arst_o = term_i[N_ROWS-2];
  assign spre_o = term_i[N_ROWS-1];

endmodule

// File: rtl/pla_core.sv
module pla_core
  import pla_pkg::*;
#(
  parameter int N_IN      = 12,
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_COL    = 2 * (N_IN + N_OUT),
  localparam int N_ROWS   = group_base(N_OUT, N_OUT, MIN_TERMS, TERM_STEP) + 2,
  localparam int N_FUSE   = N_ROWS * N_COL
) (
  input  logic [N_IN-1:0]   din_i,
  input  logic [N_OUT-1:0]  fb_i,
  input  logic [N_FUSE-1:0] fuse_i,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  oe_o,
  output logic              arst_o,
  output logic              spre_o
);

  logic [N_COL-1:0]  col;
  logic [N_ROWS-1:0] term;

  pla_literals #(.N_IN(N_IN), .N_OUT(N_OUT)) u_lit (
    .din_i (din_i),
    .fb_i  (fb_i),
    .col_o (col)
  );

  pla_and_plane #(.N_COL(N_COL), .N_ROWS(N_ROWS)) u_and (
    .col_i  (col),
    .fuse_i (fuse_i),
    .term_o (term)
  );

  pla_or_plane #(.N_OUT(N_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP)) u_or (
    .term_i (term),
    .sum_o  (sum_o),
    .oe_o   (oe_o),
    .arst_o (arst_o),
    .spre_o (spre_o)
  );

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk
  import pla_pkg::*;
#(
  parameter int N_IN      = 12,
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_COL    = 2 * (N_IN + N_OUT),
  localparam int N_ROWS   = group_base(N_OUT, N_OUT, MIN_TERMS, TERM_STEP) + 2,
  localparam int N_FUSE   = N_ROWS * N_COL
) (
  input logic [N_FUSE-1:0] fuse_i,
  input logic [N_OUT-1:0]  sum_o,
  input logic [N_OUT-1:0]  oe_o,
  input logic              arst_o,
  input logic              spre_o
);

  function automatic logic row_intact(input int r);
    return &fuse_i[r*N_COL +: N_COL];
  endfunction

  function automatic logic row_blown(input int r);
    return ~|fuse_i[r*N_COL +: N_COL];
  endfunction

  always_comb begin
    if (row_intact(N_ROWS-2))
      AST_CLR_INTACT_LOW: assert (!arst_o) else $error("clear term high with intact row"); // R3
    if (row_blown(N_ROWS-1))
      AST_SET_BLOWN_HIGH: assert (spre_o) else $error("set term low with blown row"); // R4
    for (int k = 0; k < N_OUT; k++) begin
      if (row_blown(group_base(k, N_OUT, MIN_TERMS, TERM_STEP)))
        AST_OE_BLOWN_HIGH: assert (oe_o[k]) else $error("enable low with blown row"); // R7
      for (int t = 0; t < terms_of(k, N_OUT, MIN_TERMS, TERM_STEP); t++) begin
        if (row_blown(group_base(k, N_OUT, MIN_TERMS, TERM_STEP) + 1 + t))
          AST_SUM_TERM_HIGH: assert (sum_o[k]) else $error("sum low with a true term"); // R5
      end
    end
  end

endmodule

bind pla_core pla_core_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP)
) u_chk (
  .fuse_i (fuse_i),
  .sum_o  (sum_o),
  .oe_o   (oe_o),
  .arst_o (arst_o),
  .spre_o (spre_o)
);

// File: tb/tb_pla_core.sv
module tb_pla_core;

  localparam int NC = 44;
  localparam int NR = 132;
  localparam int NF = NR * NC;
  localparam int CNT [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  typedef struct packed {
    int          outn;
    int          term;
    int          ca;
    int          cb;
    logic [11:0] din;
    logic [9:0]  fb;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{0, 0, 0, 3, 12'h001, 10'h000, 1'b1},
    '{0, 0, 0, 3, 12'h003, 10'h000, 1'b0},
    '{4, 15, 24, 23, 12'h000, 10'h001, 1'b1},
    '{4, 15, 24, 23, 12'h800, 10'h001, 1'b0},
    '{9, 7, 43, 22, 12'h800, 10'h000, 1'b1},
    '{9, 7, 43, 22, 12'h800, 10'h200, 1'b0},
    '{5, 0, 2, 2, 12'h002, 10'h000, 1'b1},
    '{5, 0, 2, 2, 12'h000, 10'h000, 1'b0}
  };

  logic          clk;
  logic          rst_n;
  logic [11:0]   din;
  logic [9:0]    fb;
  logic [NF-1:0] fuse;
  logic [9:0]    sum;
  logic [9:0]    oe;
  logic          arst;
  logic          spre;
  int            checks;
  int            fails;

  pla_core dut (
    .din_i  (din),
    .fb_i   (fb),
    .fuse_i (fuse),
    .sum_o  (sum),
    .oe_o   (oe),
    .arst_o (arst),
    .spre_o (spre)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int base_of(input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += 1 + CNT[j];
    return acc;
  endfunction

  task automatic set_row(input int r, input logic [NC-1:0] v);
    fuse[r*NC +: NC] = v;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [NC-1:0] pat;
    rst_n = 1'b0;
    din   = '0;
    fb    = '0;
    fuse  = '1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();
    // R3: all rows intact -> every term low
    chk("R3 reset state", {sum, oe, arst, spre}, 22'h0);
    din = 12'hA5C; fb = 10'h3F1;
    settle();
    chk("R3 intact rows any inputs", {sum, oe, arst, spre}, 22'h0);

    // R1 R2 R5 R6: table of single-term programs
    foreach (VECS[i]) begin
      fuse = '1;
      pat  = '0;
      pat[VECS[i].ca] = 1'b1;
      pat[VECS[i].cb] = 1'b1;
      set_row(base_of(VECS[i].outn) + 1 + VECS[i].term, pat);
      din = VECS[i].din;
      fb  = VECS[i].fb;
      settle();
      chk("R2 R1 target sum", 32'(sum[VECS[i].outn]), 32'(VECS[i].exp));
      chk("R5 R6 other outputs", {sum, oe, arst, spre},
          {10'(VECS[i].exp) << VECS[i].outn, 10'h0, 2'b00});
    end

    // R4: everything blown -> all terms high
    fuse = '0;
    settle();
    chk("R4 all blown", {sum, oe, arst, spre}, {10'h3FF, 10'h3FF, 2'b11});

    // R7: enable row of output 3 blown
    fuse = '1;
    set_row(base_of(3), '0);
    settle();
    chk("R7 enable row", {sum, oe, arst, spre}, {10'h000, 10'h008, 2'b00});

    // R8: clear row then set row
    fuse = '1;
    set_row(130, '0);
    settle();
    chk("R8 clear row", {sum, oe, arst, spre}, {20'h0, 2'b10});
    fuse = '1;
    set_row(131, '0);
    settle();
    chk("R8 set row", {sum, oe, arst, spre}, {20'h0, 2'b01});

    // R10: last row of output 1 group, then the row just after it
    fuse = '1;
    set_row(base_of(1) + CNT[1], '0);
    settle();
    chk("R10 last row of group", {sum, oe}, {10'h002, 10'h000});
    fuse = '1;
    set_row(base_of(1) + CNT[1] + 1, '0);
    settle();
    chk("R10 row after group", {sum, oe}, {10'h000, 10'h004});

    // R9: output follows input with no clock edge in between
    fuse = '1;
    pat  = '0;
    pat[0] = 1'b1;
    set_row(base_of(0) + 1, pat);
    din = '0;
    fb  = '0;
    @(posedge clk);
    #1;
    chk("R9 before change", 32'(sum[0]), 32'd0);
    din = 12'h001;
    #1;
    chk("R9 after change", 32'(sum[0]), 32'd1);
    fuse[NC + 0] = 1'b0;
    fuse[NC + 1] = 1'b1;
    #1;
    chk("R9 fuse change", 32'(sum[0]), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule